// File: doc/BRIEF.md
# Watchdog and Reset Pulse Supervisor

This block produces the active-low reset for a processor. Two events start a reset: the supply-good bit from an external comparator going low, and a watchdog that has not been serviced in time. In both cases a pulse generator keeps the reset output low for a fixed minimum number of clock cycles. The minimum pulse starts counting only once the supply is good again. While the supply stays bad, the reset stays low for as long as that lasts.

The watchdog input comes from a three-level pin. It therefore reaches the block as two bits: a level and a flag that marks the pin as undriven. When the pin is undriven, the watchdog does nothing. When the pin is driven, every change of level, rising or falling, restarts the timeout. If software stops toggling the pin, the block issues a reset pulse once per timeout period until someone services it again. The timeout and the pulse length are parameters counted in clock cycles.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is low. After `rst_n` is released, `sys_rst_n` stays low for exactly PULSE_CYC cycles, counted from the first edge that samples `rst_n` high, and then goes high.
- R2: On the edge after `pwr_good` is sampled low, `sys_rst_n` goes low. It stays low for every cycle in which `pwr_good` remains low.
- R3: Once `pwr_good` is sampled high again, `sys_rst_n` stays low for exactly PULSE_CYC cycles and then goes high.
- R4: `wd_level` and `wd_float` each pass through two synchronising flops. A change on either pin reaches the watchdog logic on the third rising edge after the change.
- R5: Every transition of the synchronised level, rising or falling, clears the watchdog count. A pin that toggles every 15 cycles, with a 20-cycle timeout, never causes a reset.
- R6: With the watchdog enabled and reset released, if the level does not change, `sys_rst_n` falls TIMEOUT_CYC+3 edges after the last pin change (two synchroniser edges plus one edge-detect edge, then TIMEOUT_CYC counted cycles).
- R7: While the watchdog stays unserviced, the output repeats a fixed pattern: low for PULSE_CYC cycles, then high for exactly TIMEOUT_CYC cycles.
- R8: While `wd_float` is high (1 = pin undriven), no timeout ever occurs, however long the level stays constant.
- R9: A change of `wd_float` from 1 to 0 counts as a kick. The timeout is then counted from that change in the same way as in R6.
- R10: The watchdog count stays at zero while reset is asserted. After a release, the full TIMEOUT_CYC is counted before the next timeout.
- R11: A supply failure during a watchdog pulse takes priority. When the supply returns, a full PULSE_CYC pulse is counted from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block's own flops |
| pwr_good | input | 1 | 1 = supply above threshold, already synchronous to clk |
| wd_level | input | 1 | Driven level of the three-level watchdog pin |
| wd_float | input | 1 | 1 = watchdog pin undriven (watchdog disabled) |
| sys_rst_n | output | 1 | Registered active-low reset for the processor |

## Verification
The embedded assertions check on every cycle the relations that hold locally:
- a bad supply forces reset on the following edge;
- the pulse and watchdog counters stay below their limits;
- a kick or a held reset zeroes the watchdog count;
- no timeout fires while the pulse is active.

Only the bench scenarios can show the following:
- exact end-to-end durations, including the three-edge path through synchroniser and edge detector;
- the periodic pattern of repeated pulses;
- that both edge directions service the timer;
- that a floating-to-driven change restarts timing rather than merely enabling it;
- that a supply failure in the middle of a watchdog pulse yields a full-length pulse afterwards.

// File: rtl/sup_pkg.sv
// Package: shared types for the reset supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package sup_pkg;

    // Cause selected for (re)starting the reset pulse, in priority order.
    typedef enum logic [1:0] {
        TRIG_NONE = 2'd0,
        TRIG_WDOG = 2'd1,
        TRIG_PWR  = 2'd2
    } trig_e;

    // Picks the dominant trigger; a supply failure always wins.
    function automatic trig_e pick_trig(input logic pwr_bad, input logic wd_exp);
        if (pwr_bad)
            return TRIG_PWR;
        else if (wd_exp)
            return TRIG_WDOG;
        else
            return TRIG_NONE;
    endfunction

endpackage

// File: rtl/sup_sync2.sv
// Module: sup_sync2
// Two-stage synchroniser for a vector of independent asynchronous bits.
// Assumes: the bits are unrelated, so no bus coherency is needed; the
// reset value of each bit is given by RST_VAL.
module sup_sync2 #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two flops per bit to let metastability settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;

endmodule

// File: rtl/sup_wd_timer.sv
// Module: sup_wd_timer
// Watchdog timeout counter with edge-based kicking.
// Assumes: lvl_s and flt_s are already synchronous; hold is high while the
// reset pulse is active, and the count stays at zero during that time.
// It raises a one-cycle expire when TIMEOUT_CYC cycles pass with no kick.
module sup_wd_timer #(
    parameter int TIMEOUT_CYC = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_s,
    input  logic flt_s,
    input  logic hold,
    output logic expire
);

    localparam int WW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [WW-1:0] LAST = WW'(TIMEOUT_CYC - 1);

    logic          lvl_prev;
    logic          flt_prev;
    logic [WW-1:0] wcnt;
    logic          enabled;
    logic          kick;
    logic          at_last;

    // Watchdog runs only while the pin is actively driven.
    assign enabled = !flt_s;

    // Kick on any level change, or on the pin becoming driven.
    assign kick = (lvl_s != lvl_prev) || (flt_prev && !flt_s);

    // Current count is the final one of the timeout window.
    assign at_last = (wcnt == LAST);

    // Timeout pulse when the last count passes with nothing interfering.
    assign expire = enabled && !hold && !kick && at_last;

    // Remember the previous synchronised pin state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev <= 1'b0;
            flt_prev <= 1'b1;
        end else begin
            lvl_prev <= lvl_s;
            flt_prev <= flt_s;
        end
    end

    // Timeout counter: cleared by hold, disable, kick or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (hold || !enabled || kick || at_last) begin
            wcnt <= '0;
        end else begin
            wcnt <= wcnt + 1'b1;
        end
    end

    AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= LAST);                                          // R6
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (wcnt == '0));                                 // R10
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && !$isunknown(kick)) |=> (wcnt == '0));          // R5
    AST_FLOAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        flt_s |=> (wcnt == '0));                                // R8

endmodule

// File: rtl/sup_pulse_gen.sv
// Module: sup_pulse_gen
// Reset pulse generator with a minimum active length.
// Assumes: pwr_good is synchronous to clk and wd_expire is a one-cycle
// strobe. Each trigger clears the count, so a pulse always lasts the full
// PULSE_CYC cycles from the last cycle that asserted a trigger.
module sup_pulse_gen
    import sup_pkg::*;
#(
    parameter int PULSE_CYC = 17_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic wd_expire,
    output logic rst_active
);

    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] LAST = PW'(PULSE_CYC - 1);

    logic [PW-1:0] pcnt;
    trig_e         trig;

    // Select the winning trigger for this cycle.
    assign trig = pick_trig(!pwr_good, wd_expire);

    // Pulse state: retrigger restarts, otherwise count to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_active <= 1'b1;
            pcnt       <= '0;
        end else begin
            case (trig)
                TRIG_PWR, TRIG_WDOG: begin
                    rst_active <= 1'b1;
                    pcnt       <= '0;
                end
                default: begin
                    if (rst_active) begin
                        if (pcnt == LAST) begin
                            rst_active <= 1'b0;
                            pcnt       <= '0;
                        end else begin
                            pcnt <= pcnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    AST_PWRFAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> rst_active);                              // R2
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= LAST);                                          // R3
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_active && pcnt < LAST) |=> rst_active);            // R3
    AST_QUIET_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |-> !wd_expire);                             // R10
    AST_RESTART_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good || wd_expire) |=> (pcnt == '0));             // R11

endmodule

// File: rtl/rst_supervisor.sv
// Module: rst_supervisor
// Top of the reset supervisor. Synchronises the watchdog pin bits, runs the
// watchdog timer and drives the registered active-low processor reset.
// Assumes: pwr_good is already synchronous; rst_n resets only this block.
module rst_supervisor #(
    parameter int TIMEOUT_CYC = 200_000_000,
    parameter int PULSE_CYC   = 17_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic wd_level,
    input  logic wd_float,
    output logic sys_rst_n
);

    localparam int SYNC_W = 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = 2'b10; // {float, level}

    logic [SYNC_W-1:0] pin_s;
    logic              wd_expire;
    logic              rst_active;

    sup_sync2 #(
        .W       (SYNC_W),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({wd_float, wd_level}),
        .q_sync  (pin_s)
    );

    sup_wd_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_s  (pin_s[0]),
        .flt_s  (pin_s[1]),
        .hold   (rst_active),
        .expire (wd_expire)
    );

    sup_pulse_gen #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .wd_expire  (wd_expire),
        .rst_active (rst_active)
    );

    // Output is the inverted registered pulse state.
    assign sys_rst_n = !rst_active;

    AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> !sys_rst_n);                              // R6
    AST_PWR_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !sys_rst_n);                              // R2

endmodule

// File: tb/sim_rst_supervisor.sv
// Bench: scoreboard. The driver queues the expected output for each coming
// cycle; the monitor pops one item at every falling edge and compares it.
module sim_rst_supervisor;

    localparam int T = 20;
    localparam int P = 6;

    typedef struct {
        bit    val;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n, pwr_good, wd_level, wd_float;
    logic sys_rst_n;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    rst_supervisor #(.TIMEOUT_CYC(T), .PULSE_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .wd_level(wd_level), .wd_float(wd_float), .sys_rst_n(sys_rst_n)
    );

    // Monitor: compare one queued expectation per cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (sys_rst_n !== e.val) begin
                n_fail++;
                $display("FAIL %s: sys_rst_n=%b expected %b at %0t",
                         e.req, sys_rst_n, e.val, $time);
            end
        end
    end

    // Queue n expected values, then let those cycles run.
    task automatic expect_run(input int n, input bit v, input string req);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.val = v;
            e.req = req;
            exp_q.push_back(e);
        end
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    // Watchdog on the bench itself.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, got no end expected end");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; pwr_good = 1'b1; wd_level = 1'b0; wd_float = 1'b1;
        @(negedge clk); #1;
        expect_run(4, 1'b0, "R1");             // reset state
        rst_n = 1'b1;
        expect_run(P - 1, 1'b0, "R1");         // power-on pulse
        expect_run(3 * T, 1'b1, "R8");         // floating: no timeout

        // Supply failure and return.
        pwr_good = 1'b0;
        expect_run(40, 1'b0, "R2");
        pwr_good = 1'b1;
        expect_run(P - 1, 1'b0, "R3");
        expect_run(T, 1'b1, "R3");

        // Drive the pin and toggle every 15 cycles: both edges service.
        wd_float = 1'b0;
        expect_run(15, 1'b1, "R5");
        for (int k = 0; k < 8; k++) begin
            wd_level = ~wd_level;
            expect_run(15, 1'b1, "R5");
        end

        // Stop servicing: timeout, then periodic pulses.
        wd_level = ~wd_level;
        expect_run(T + 2, 1'b1, "R6 R4");
        for (int k = 0; k < 2; k++) begin
            expect_run(P, 1'b0, "R7");
            expect_run(T, 1'b1, "R7 R10");
        end
        expect_run(2, 1'b0, "R6");

        // Supply fails in the middle of a watchdog pulse.
        pwr_good = 1'b0;
        expect_run(10, 1'b0, "R2");
        pwr_good = 1'b1;
        expect_run(P - 1, 1'b0, "R11");
        expect_run(T, 1'b1, "R10");
        expect_run(1, 1'b0, "R7");

        // Float the pin during the pulse: watchdog goes quiet.
        wd_float = 1'b1;
        expect_run(P - 1, 1'b0, "R7");
        expect_run(3 * T, 1'b1, "R8");

        // Floating to driven with a constant level is a kick.
        wd_float = 1'b0;
        expect_run(T + 2, 1'b1, "R9");
        expect_run(P, 1'b0, "R9");
        expect_run(2, 1'b1, "R9");

        done = 1'b1;
        finish_run();
    end

endmodule